// File: doc/BRIEF.md
# Stack-Addressed Floating-Point Register File

This block holds eight 80-bit floating-point registers and presents them as a push-down stack. A moving top pointer marks the current top. Every operand index is an offset from that top: ST(0) is the most recently pushed live value and ST(1) is the one beneath it. The block drives two source operands to an external arithmetic unit and writes that unit's result back in the same cycle. The destination is either ST(0) or ST(i). A reverse control swaps which register is the first source and which is the second. A pop control removes ST(0) after the result is written.

A load path pushes a new value onto the stack, and a store path reads ST(0) and pops it in the same request. Each physical slot carries a valid tag. A push onto a live slot raises overflow. A read of an empty slot raises underflow. A pop with both destination and source at ST(0) is rejected as illegal. Any of these errors leaves the stack untouched. Reads are combinational. Writes, pushes and pops take effect on the rising clock edge. An asynchronous active-low reset, released synchronously upstream, empties the stack and sets the top pointer to 0.

Top module: `fp_stack_regfile`

## Requirements
- R1: After reset the stack is empty: a store-pop or any operation raises underflow, and the first push is accepted.
- R2: An accepted push places push_data at ST(0) from the next cycle, and every earlier entry ST(k) becomes ST(k+1).
- R3: A push while all 8 entries are live raises err_overflow for that cycle and changes neither the contents nor the depth.
- R4: Reads are relative to the top: with op_dst_top=1, src_b shows ST(op_idx) in the same cycle, whether or not a request is present.
- R5: The destination is ST(0) when op_dst_top=1 (the other operand is ST(op_idx)) and ST(op_idx) when op_dst_top=0 (the other operand is ST(0)). With op_rev=0, src_a is the destination register and src_b is the other operand. With op_rev=1 the two are swapped.
- R6: An accepted operation writes res_data into the destination register at the clock edge.
- R7: An operation with op_pop=1 writes the result first and then pops ST(0), so the old ST(k) becomes ST(k-1) and a result written to ST(i) appears at ST(i-1).
- R8: An operation with op_pop=1 and op_idx=0 raises err_illegal and leaves the stack unchanged.
- R9: An operation that names an empty entry as destination or source raises err_underflow and leaves the stack unchanged.
- R10: store_data always shows ST(0). An accepted store-pop removes ST(0). A store-pop on an empty stack raises err_underflow and changes nothing.
- R11: Only one request is served per cycle, in the priority operation, then push, then store-pop. Lower-priority requests in the same cycle are ignored, and at most one error flag is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Two-operand operation request |
| op_dst_top | input | 1 | 1: destination ST(0), other operand ST(op_idx); 0: destination ST(op_idx), other operand ST(0) |
| op_idx | input | 3 | Stack offset i of the non-top operand |
| op_rev | input | 1 | Swap the first and second source |
| op_pop | input | 1 | Pop ST(0) after the result is written |
| src_a | output | 80 | First source operand to the arithmetic unit |
| src_b | output | 80 | Second source operand to the arithmetic unit |
| res_data | input | 80 | Result from the arithmetic unit |
| push_valid | input | 1 | Load request: push push_data |
| push_data | input | 80 | Value to push |
| store_pop | input | 1 | Store request: pop ST(0) |
| store_data | output | 80 | Current ST(0) |
| err_overflow | output | 1 | Push rejected: stack full |
| err_underflow | output | 1 | Request rejected: empty entry referenced |
| err_illegal | output | 1 | Operation rejected: pop with op_idx 0 |

## Verification
The bench keeps the stack as a queue whose front is ST(0), with no pointer or tags. It runs the top pointer through several wraps and compares both sources, store_data and the error flags on every cycle. It fills the stack to eight entries and pushes again. A design that checks the wrong slot for overflow would overwrite the bottom entry, and the later pops would show this. Operations with pop and a destination of ST(i) are checked on the following cycle at ST(i-1). A design that pops before it writes would put the result one entry off. The bench also issues illegal pops and reads of empty entries, then walks the stack. A design that updates state on a rejected request shows a shifted or lost entry. Randomly combined requests check the priority order, because a design that serves two requests at once shows a depth change of two.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_OP   = 2'd1,
    REQ_PUSH = 2'd2,
    REQ_POP  = 2'd3
  } req_kind_e;
endpackage

// File: rtl/fsr_ptr.sv
module fsr_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_inc,
  input  logic             ptr_dec,
  output logic [PTR_W-1:0] top_q
);
  logic [PTR_W-1:0] top_d;
  logic             top_en;

  always_comb begin
    top_en = ptr_inc | ptr_dec;
    top_d  = top_q;
    if (ptr_inc)      top_d = top_q + 1'b1;
    else if (ptr_dec) top_d = top_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top_q <= '0;
    else if (top_en) top_q <= top_d;
  end
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic [PTR_W-1:0] top_q,
  input  logic [DEPTH-1:0] vld_q,
  input  logic             op_valid,
  input  logic             op_dst_top,
  input  logic [PTR_W-1:0] op_idx,
  input  logic             op_pop,
  input  logic             push_valid,
  input  logic             store_pop,
  output logic [PTR_W-1:0] dst_addr,
  output logic [PTR_W-1:0] oth_addr,
  output logic [PTR_W-1:0] push_addr,
  output logic             wr_en,
  output logic             wr_push,
  output logic             set_en,
  output logic             clr_en,
  output logic             ptr_inc,
  output logic             ptr_dec,
  output logic             err_overflow,
  output logic             err_underflow,
  output logic             err_illegal
);
  req_kind_e        kind;
  logic [PTR_W-1:0] dst_off;
  logic [PTR_W-1:0] oth_off;
  logic             opnd_ok;
  logic             pop_bad;

  always_comb begin
    if (op_valid)        kind = REQ_OP;
    else if (push_valid) kind = REQ_PUSH;
    else if (store_pop)  kind = REQ_POP;
    else                 kind = REQ_NONE;
  end

  always_comb begin
    dst_off   = op_dst_top ? '0 : op_idx;
    oth_off   = op_dst_top ? op_idx : '0;
    dst_addr  = top_q + dst_off;
    oth_addr  = top_q + oth_off;
    push_addr = top_q - 1'b1;
    opnd_ok   = vld_q[dst_addr] & vld_q[oth_addr];
    pop_bad   = op_pop & (op_idx == '0);
  end

  always_comb begin
    wr_en         = 1'b0;
    wr_push       = 1'b0;
    set_en        = 1'b0;
    clr_en        = 1'b0;
    ptr_inc       = 1'b0;
    ptr_dec       = 1'b0;
    err_overflow  = 1'b0;
    err_underflow = 1'b0;
    err_illegal   = 1'b0;
    unique case (kind)
      REQ_OP: begin
        if (pop_bad) begin
          err_illegal = 1'b1;
        end else if (!opnd_ok) begin
          err_underflow = 1'b1;
        end else begin
          wr_en   = 1'b1;
          clr_en  = op_pop;
          ptr_inc = op_pop;
        end
      end
      REQ_PUSH: begin
        if (vld_q[push_addr]) begin
          err_overflow = 1'b1;
        end else begin
          wr_en   = 1'b1;
          wr_push = 1'b1;
          set_en  = 1'b1;
          ptr_dec = 1'b1;
        end
      end
      REQ_POP: begin
        if (!vld_q[top_q]) begin
          err_underflow = 1'b1;
        end else begin
          clr_en  = 1'b1;
          ptr_inc = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fsr_bank.sv
module fsr_bank #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             set_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             clr_en,
  input  logic [PTR_W-1:0] clr_addr,
  input  logic [PTR_W-1:0] rd_a_addr,
  input  logic [PTR_W-1:0] rd_b_addr,
  input  logic [PTR_W-1:0] rd_t_addr,
  output logic [WIDTH-1:0] rd_a_data,
  output logic [WIDTH-1:0] rd_b_data,
  output logic [WIDTH-1:0] rd_t_data,
  output logic [DEPTH-1:0] vld_q
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic hit_wr;
    logic hit_clr;
    logic vld_d;
    logic vld_en;

    always_comb begin
      hit_wr  = wr_en & (wr_addr == PTR_W'(k));
      hit_clr = clr_en & (clr_addr == PTR_W'(k));
      vld_en  = hit_clr | (hit_wr & set_en);
      vld_d   = ~hit_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q[k] <= 1'b0;
      else if (vld_en) vld_q[k] <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (hit_wr) mem_q[k] <= wr_data;
    end
  end

  always_comb begin
    rd_a_data = mem_q[rd_a_addr];
    rd_b_data = mem_q[rd_b_addr];
    rd_t_data = mem_q[rd_t_addr];
  end
endmodule

// File: rtl/fp_stack_regfile.sv
module fp_stack_regfile #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_dst_top,
  input  logic [PTR_W-1:0] op_idx,
  input  logic             op_rev,
  input  logic             op_pop,
  output logic [WIDTH-1:0] src_a,
  output logic [WIDTH-1:0] src_b,
  input  logic [WIDTH-1:0] res_data,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             store_pop,
  output logic [WIDTH-1:0] store_data,
  output logic             err_overflow,
  output logic             err_underflow,
  output logic             err_illegal
);
  logic [PTR_W-1:0] top_q;
  logic [DEPTH-1:0] vld_q;
  logic [PTR_W-1:0] dst_addr;
  logic [PTR_W-1:0] oth_addr;
  logic [PTR_W-1:0] push_addr;
  logic [PTR_W-1:0] wr_addr;
  logic [WIDTH-1:0] wr_data;
  logic [WIDTH-1:0] dst_data;
  logic [WIDTH-1:0] oth_data;
  logic             wr_en;
  logic             wr_push;
  logic             set_en;
  logic             clr_en;
  logic             ptr_inc;
  logic             ptr_dec;

  fsr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .top_q        (top_q),
    .vld_q        (vld_q),
    .op_valid     (op_valid),
    .op_dst_top   (op_dst_top),
    .op_idx       (op_idx),
    .op_pop       (op_pop),
    .push_valid   (push_valid),
    .store_pop    (store_pop),
    .dst_addr     (dst_addr),
    .oth_addr     (oth_addr),
    .push_addr    (push_addr),
    .wr_en        (wr_en),
    .wr_push      (wr_push),
    .set_en       (set_en),
    .clr_en       (clr_en),
    .ptr_inc      (ptr_inc),
    .ptr_dec      (ptr_dec),
    .err_overflow (err_overflow),
    .err_underflow(err_underflow),
    .err_illegal  (err_illegal)
  );

  fsr_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ptr_inc(ptr_inc),
    .ptr_dec(ptr_dec),
    .top_q  (top_q)
  );

  always_comb begin
    wr_addr = wr_push ? push_addr : dst_addr;
    wr_data = wr_push ? push_data : res_data;
  end

  fsr_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .set_en   (set_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .clr_en   (clr_en),
    .clr_addr (top_q),
    .rd_a_addr(dst_addr),
    .rd_b_addr(oth_addr),
    .rd_t_addr(top_q),
    .rd_a_data(dst_data),
    .rd_b_data(oth_data),
    .rd_t_data(store_data),
    .vld_q    (vld_q)
  );

  // R5: the reverse control swaps the two operand ports
  always_comb begin
    src_a = op_rev ? oth_data : dst_data;
    src_b = op_rev ? dst_data : oth_data;
  end
endmodule

// File: rtl/fp_stack_regfile_chk.sv
module fp_stack_regfile_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [PTR_W-1:0] op_idx,
  input logic             op_pop,
  input logic             push_valid,
  input logic [WIDTH-1:0] push_data,
  input logic             store_pop,
  input logic [WIDTH-1:0] store_data,
  input logic             err_overflow,
  input logic             err_underflow,
  input logic             err_illegal,
  input logic [PTR_W-1:0] top_q,
  input logic [DEPTH-1:0] vld_q
);
  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !op_valid && !err_overflow) |=> (store_data == $past(push_data)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> (&vld_q));

  p_pop_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (store_pop && !op_valid && !push_valid && !err_underflow)
      |=> ($countones(vld_q) == $countones($past(vld_q)) - 1));

  p_illegal_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_pop && op_idx == '0) |-> err_illegal);

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overflow || err_underflow || err_illegal)
      |=> (top_q == $past(top_q) && vld_q == $past(vld_q)));

  p_one_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_overflow, err_underflow, err_illegal}));
endmodule

bind fp_stack_regfile fp_stack_regfile_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_idx       (op_idx),
  .op_pop       (op_pop),
  .push_valid   (push_valid),
  .push_data    (push_data),
  .store_pop    (store_pop),
  .store_data   (store_data),
  .err_overflow (err_overflow),
  .err_underflow(err_underflow),
  .err_illegal  (err_illegal),
  .top_q        (top_q),
  .vld_q        (vld_q)
);

// File: tb/fp_stack_regfile_bench.sv
`timescale 1ns/1ps
module fp_stack_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_dst_top, op_rev, op_pop;
  logic [2:0]  op_idx;
  logic [79:0] src_a, src_b, res_data, push_data, store_data;
  logic        push_valid, store_pop;
  logic        err_overflow, err_underflow, err_illegal;

  int checks = 0;
  int errors = 0;
  logic [79:0] q[$];

  always #4 clk = ~clk;

  fp_stack_regfile u_fp_stack_regfile (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_dst_top(op_dst_top), .op_idx(op_idx),
    .op_rev(op_rev), .op_pop(op_pop),
    .src_a(src_a), .src_b(src_b), .res_data(res_data),
    .push_valid(push_valid), .push_data(push_data),
    .store_pop(store_pop), .store_data(store_data),
    .err_overflow(err_overflow), .err_underflow(err_underflow),
    .err_illegal(err_illegal)
  );

  task automatic chk(input string what, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, compare before the rising edge, update model after it.
  task automatic cyc(input string tag, input bit opv, input bit dtop, input int idx,
                     input bit rev, input bit pop, input bit pushv,
                     input logic [79:0] pd, input bit spop);
    int sz = q.size();
    int di = dtop ? 0 : idx;
    int oi = dtop ? idx : 0;
    bit have = (di < sz) && (oi < sz);
    logic [79:0] ea = '0, eb = '0, res;
    bit e_ill, e_und, e_ovf;
    if (have) begin
      ea = rev ? q[oi] : q[di];
      eb = rev ? q[di] : q[oi];
    end
    res   = ea + {eb[39:0], eb[79:40]} + 80'd1;
    e_ill = opv && pop && idx == 0;
    e_und = opv ? (!e_ill && !have) : (!pushv && spop && sz == 0);
    e_ovf = !opv && pushv && sz == 8;
    op_valid = opv; op_dst_top = dtop; op_idx = 3'(idx); op_rev = rev; op_pop = pop;
    push_valid = pushv; push_data = pd; store_pop = spop; res_data = res;
    #2;
    chk({tag, " R8 err_illegal"}, 80'(err_illegal), 80'(e_ill));
    chk({tag, " R9 R10 err_underflow"}, 80'(err_underflow), 80'(e_und));
    chk({tag, " R3 err_overflow"}, 80'(err_overflow), 80'(e_ovf));
    if (have) begin
      chk({tag, " R4 R5 src_a"}, src_a, ea);
      chk({tag, " R4 R5 src_b"}, src_b, eb);
    end
    if (sz > 0) chk({tag, " R2 R10 store_data"}, store_data, q[0]);
    @(posedge clk);
    #1;
    if (opv) begin
      if (!e_ill && !e_und) begin
        q[di] = res;
        if (pop) void'(q.pop_front());
      end
    end else if (pushv) begin
      if (!e_ovf) q.push_front(pd);
    end else if (spop) begin
      if (!e_und) void'(q.pop_front());
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cyc("idle", 0, 1, 0, 0, 0, 0, '0, 0);
  endtask

  // Walk ST(0)..ST(7) on the read ports with no request.
  task automatic peek_all(input string tag);
    for (int i = 0; i < 8; i++) cyc(tag, 0, 1, i, 0, 0, 0, '0, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op_valid = 0; op_dst_top = 0; op_idx = 0; op_rev = 0; op_pop = 0;
    push_valid = 0; push_data = '0; store_pop = 0; res_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty after reset
    cyc("R1 store-pop empty", 0, 1, 0, 0, 0, 0, '0, 1);
    cyc("R1 op empty", 1, 1, 1, 0, 0, 0, '0, 0);
    cyc("R1 first push", 0, 1, 0, 0, 0, 1, 80'h1111, 0);
    // R2: pushes shift entries down
    cyc("R2 push", 0, 1, 0, 0, 0, 1, 80'h2222, 0);
    cyc("R2 push", 0, 1, 0, 0, 0, 1, 80'h3333, 0);
    peek_all("R4 peek");
    // R5/R6: operand selection and write-back
    cyc("R5 R6 dst top", 1, 1, 2, 0, 0, 0, '0, 0);
    cyc("R5 R6 dst top rev", 1, 1, 1, 1, 0, 0, '0, 0);
    cyc("R5 R6 dst i", 1, 0, 2, 0, 0, 0, '0, 0);
    cyc("R5 R6 dst i rev", 1, 0, 1, 1, 0, 0, '0, 0);
    peek_all("R6 after writes");
    // R9: empty operand
    cyc("R9 empty src", 1, 1, 5, 0, 0, 0, '0, 0);
    cyc("R9 empty dst", 1, 0, 3, 1, 1, 0, '0, 0);
    // R8: illegal pop
    cyc("R8 illegal top", 1, 1, 0, 0, 1, 0, '0, 0);
    cyc("R8 illegal i", 1, 0, 0, 1, 1, 0, '0, 0);
    peek_all("R8 R9 unchanged");
    // R3: fill and overflow
    for (int k = 0; k < 6; k++) cyc("R3 fill", 0, 1, 0, 0, 0, 1, 80'hA000 + 80'(k), 0);
    cyc("R3 overflow", 0, 1, 0, 0, 0, 1, 80'hDEAD, 0);
    peek_all("R3 unchanged");
    // R7: op with pop, destination ST(i)
    cyc("R7 pop dst i", 1, 0, 3, 0, 1, 0, '0, 0);
    peek_all("R7 renumber");
    cyc("R7 pop dst top", 1, 1, 4, 1, 1, 0, '0, 0);
    peek_all("R7 renumber2");
    // R11: simultaneous requests
    cyc("R11 op over push", 1, 0, 1, 0, 0, 1, 80'hBEEF, 1);
    cyc("R11 push over pop", 0, 1, 0, 0, 0, 1, 80'hCAFE, 1);
    peek_all("R11 after");
    // R10: drain then underflow
    for (int k = 0; k < 8; k++) cyc("R10 store-pop", 0, 1, 0, 0, 0, 0, '0, 1);
    cyc("R10 underflow", 0, 1, 0, 0, 0, 0, '0, 1);
    idle();
    // Mixed traffic, pointer wraps many times
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 9);
      bit opv = (r < 4);
      bit pv  = (r >= 3 && r < 7) || ($urandom_range(0, 7) == 0);
      bit sp  = (r >= 6) || ($urandom_range(0, 7) == 0);
      cyc("R11 mixed", opv, 1'($urandom_range(0, 1)), $urandom_range(0, 7),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), pv,
          {$urandom, $urandom, 16'($urandom)}, sp);
      if (n % 200 == 0) peek_all("R4 R7 walk");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule